// File: doc/BRIEF.md
# Vectored Interrupt Aggregator

This block gathers up to 32 interrupt request lines into one interrupt line towards a processor. Software uses a small 32-bit register bus to reach it. The bus has a byte address, a write strobe, write data and combinational read data. Eight word registers are reachable: a status word, an enable mask, a pending word, a vector and a two-bit master control. Three of them are write-only command words: acknowledge, enable-set and enable-clear.

Each source is fixed at build time as edge-sensitive or level-sensitive through the parameter `EDGE_MASK`. A 1 bit makes that source edge-sensitive. A level source's status bit tracks its input. An edge source's status bit latches a rising edge and stays set until software acknowledges it.

The pending word is always status AND enable. The vector gives the lowest-numbered pending source, so source 0 has the highest priority.

Top module: `irq_hub`

## Requirements
- R1: After reset, status, enable and master read zero, pending reads zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: Registers sit at these byte offsets:
  - status 0x00
  - pending 0x04
  - enable 0x08
  - acknowledge 0x0C
  - enable-set 0x10
  - enable-clear 0x14
  - vector 0x18
  - master 0x1C, with bit 0 = output enable and bit 1 = capture enable.
- R2 (continued): Reads of acknowledge, enable-set, enable-clear and of any address with nonzero bits [1:0] return zero. Writes to such addresses have no effect.
- R3: The pending word reads as status AND enable in every cycle.
- R4: The vector reads the index of the lowest set pending bit. It reads 0xFFFFFFFF when no bit is pending.
- R5: `irq_out` is high exactly when both master bits are 1 and the pending word is nonzero.
- R6: A write to acknowledge clears the status bits written as 1 and leaves the others unchanged. An edge status bit never clears without such a write, or without a plain status write. A level bit with capture enabled is loaded from its input again on the same edge.
- R7: A write to enable-set ORs the data into the enable mask. A write to enable-clear clears the mask bits written as 1. No other bit changes.
- R8: Plain writes to status, enable and master replace their contents. Writes to pending and vector change nothing.
- R9: With capture enabled, a level status bit equals its input as sampled on the previous clock edge.
- R10: With capture enabled, a 0-to-1 change of an edge input between two edges sets its status bit on the second edge. A later fall of that input leaves the bit set.
- R11: With capture disabled, input activity does not change status and `irq_out` is low.
- R12: When an edge source rises in the same cycle that its status bit is acknowledged, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_in | input | NSRC | Interrupt request lines |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The assertions assume that `irq_in` is synchronous to `clk` and held low during reset. If it were not, the first edge after reset would show a spurious rising edge, and the one-cycle level and edge relations would not hold.

The hold-while-disabled property assumes that nothing else writes status in that cycle, so it is conditioned on `bus_we` being low.

The bench drives every input half a period away from the rising edge, from one synchronous stream. It keeps the inputs at zero through reset. The random phase mixes all eight offsets with misaligned addresses and random request patterns, and biases the master word towards both bits set so that capture and output stay active most of the time.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;

    // Word index field of the byte address, above the two alignment bits.
    localparam int unsigned REG_IDX_W = 3;
    localparam int unsigned WORD_LSB  = 2;
    localparam int unsigned ADDR_W    = REG_IDX_W + WORD_LSB;

    // Master control bit positions.
    localparam int unsigned MST_OUT_BIT = 0;
    localparam int unsigned MST_CAP_BIT = 1;
    localparam int unsigned MST_W       = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_STATUS = 3'd0,
        IDX_PEND   = 3'd1,
        IDX_ENABLE = 3'd2,
        IDX_ACK    = 3'd3,
        IDX_SETEN  = 3'd4,
        IDX_CLREN  = 3'd5,
        IDX_VEC    = 3'd6,
        IDX_MASTER = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/irq_hub_edge.sv
`timescale 1ns/1ps
module irq_hub_edge #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] rise
);

    logic [NSRC-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = req;
        rise   = req & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/irq_hub_prio.sv
`timescale 1ns/1ps
module irq_hub_prio #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic [NSRC-1:0]   pend,
    output logic [DATA_W-1:0] vec
);

    // Scan from the top down so the lowest set index is the one that stays.
    always_comb begin
        vec = '1;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) vec = DATA_W'(i);
        end
    end

endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned     NSRC      = 32,
    parameter int unsigned     DATA_W    = 32,
    parameter logic [NSRC-1:0] EDGE_MASK = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   irq_in,
    output logic              irq_out
);

    typedef struct packed {
        logic [NSRC-1:0]  status;
        logic [NSRC-1:0]  enable;
        logic [MST_W-1:0] master;
    } regs_t;

    regs_t st_d, st_q;

    logic [NSRC-1:0]     status_now, enable_now, pend_now, rise;
    logic [MST_W-1:0]    master_now;
    logic [DATA_W-1:0]   vec_now;
    logic                aligned;
    reg_idx_e            idx;
    logic [NSRC-1:0]     wr_bits;
    logic [NSRC-1:0]     base;

    assign status_now = st_q.status;
    assign enable_now = st_q.enable;
    assign master_now = st_q.master;
    assign pend_now   = status_now & enable_now;
    assign aligned    = (bus_addr[WORD_LSB-1:0] == '0);
    assign idx        = reg_idx_e'(bus_addr[ADDR_W-1:WORD_LSB]);
    assign wr_bits    = bus_wdata[NSRC-1:0];

    irq_hub_edge #(.NSRC(NSRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_in),
        .rise  (rise)
    );

    irq_hub_prio #(.NSRC(NSRC), .DATA_W(DATA_W)) u_prio (
        .pend (pend_now),
        .vec  (vec_now)
    );

    // Next-state: register writes first, then input capture on top.
    always_comb begin
        st_d = st_q;
        base = st_q.status;
        if (bus_we && aligned) begin
            unique case (idx)
                IDX_STATUS: base        = wr_bits;
                IDX_ACK:    base        = st_q.status & ~wr_bits;
                IDX_ENABLE: st_d.enable = wr_bits;
                IDX_SETEN:  st_d.enable = st_q.enable | wr_bits;
                IDX_CLREN:  st_d.enable = st_q.enable & ~wr_bits;
                IDX_MASTER: st_d.master = bus_wdata[MST_W-1:0];
                default: ;
            endcase
        end
        st_d.status = base;
        if (st_q.master[MST_CAP_BIT]) begin
            for (int i = 0; i < int'(NSRC); i++) begin
                if (EDGE_MASK[i]) st_d.status[i] = base[i] | rise[i];
                else              st_d.status[i] = irq_in[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (idx)
                IDX_STATUS: bus_rdata = DATA_W'(status_now);
                IDX_PEND:   bus_rdata = DATA_W'(pend_now);
                IDX_ENABLE: bus_rdata = DATA_W'(enable_now);
                IDX_VEC:    bus_rdata = vec_now;
                IDX_MASTER: bus_rdata = DATA_W'(master_now);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq_out = master_now[MST_OUT_BIT] & master_now[MST_CAP_BIT] & (|pend_now);

endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk #(
    parameter int unsigned     NSRC      = 32,
    parameter int unsigned     DATA_W    = 32,
    parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [NSRC-1:0]   irq_in,
    input logic              irq_out,
    input logic [NSRC-1:0]   status,
    input logic [1:0]        master,
    input logic [NSRC-1:0]   rise,
    input logic [NSRC-1:0]   pend,
    input logic [DATA_W-1:0] vec
);

    localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    assert_vec_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (vec == '1));

    assert_vec_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> (pend[vec[IDX_W-1:0]] &&
                          ((pend & ~({NSRC{1'b1}} << vec[IDX_W-1:0])) == '0)));

    assert_out_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master != 2'b11) |-> !irq_out);

    assert_out_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master == 2'b11 && pend != '0) |-> irq_out);

    assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((EDGE_MASK & $past(status) & ~status) == '0));

    assert_level_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        master[1] |=> ((status & ~EDGE_MASK) == ($past(irq_in) & ~EDGE_MASK)));

    // R10 and R12: a captured rising edge is set whatever the write did.
    assert_edge_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (master[1] && ((rise & EDGE_MASK) != '0)) |=>
        ((status & $past(rise & EDGE_MASK)) == $past(rise & EDGE_MASK)));

    assert_capture_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!master[1] && !bus_we) |=> $stable(status));

endmodule

bind irq_hub irq_hub_chk #(
    .NSRC      (NSRC),
    .DATA_W    (DATA_W),
    .EDGE_MASK (EDGE_MASK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_we  (bus_we),
    .irq_in  (irq_in),
    .irq_out (irq_out),
    .status  (status_now),
    .master  (master_now),
    .rise    (rise),
    .pend    (pend_now),
    .vec     (vec_now)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;

    localparam logic [31:0] EDGE = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_stat = '0, m_en = '0, m_prev = '0;
    logic [1:0]  m_mst = '0;

    always #2 clk = ~clk;

    irq_hub #(.NSRC(32), .DATA_W(32), .EDGE_MASK(EDGE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] vec_of(input logic [31:0] p);
        logic [31:0] v = 32'hFFFF_FFFF;
        for (int i = 31; i >= 0; i--) if (p[i]) v = i;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_we = 1'b0;
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        logic [31:0] p = m_stat & m_en;
        rd(5'h00, d); check({tag, " R8 status"}, d, m_stat);
        rd(5'h04, d); check({tag, " R3 pending"}, d, p);
        rd(5'h08, d); check({tag, " R7 enable"}, d, m_en);
        rd(5'h18, d); check({tag, " R4 vector"}, d, vec_of(p));
        rd(5'h1C, d); check({tag, " R2 master"}, d, {30'd0, m_mst});
        check({tag, " R5 irq_out"}, {31'd0, irq_out}, {31'd0, (m_mst == 2'b11) && (p != 0)});
    endtask

    task automatic step(input logic we, input logic [4:0] a, input logic [31:0] wd,
                        input logic [31:0] inp);
        logic [31:0] base, en;
        logic [1:0]  mst;
        bus_we = we; bus_addr = a; bus_wdata = wd; irq_in = inp;
        @(posedge clk);
        base = m_stat; en = m_en; mst = m_mst;
        if (we && a[1:0] == 2'b00) begin
            case (a[4:2])
                3'd0: base = wd;
                3'd2: en = wd;
                3'd3: base = m_stat & ~wd;
                3'd4: en = m_en | wd;
                3'd5: en = m_en & ~wd;
                3'd7: mst = wd[1:0];
                default: ;
            endcase
        end
        if (m_mst[1]) base = (EDGE & (base | (inp & ~m_prev))) | (~EDGE & inp);
        m_prev = inp; m_stat = base; m_en = en; m_mst = mst;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2 R8: plain writes, misaligned and write-only reads
        step(1, 5'h08, 32'hA5A5_00FF, 0);          check_all("R8 plain enable");
        step(1, 5'h1C, 32'hFFFF_FFFF, 0);          check_all("R2 master width");
        rd(5'h0C, d); check("R2 ack reads zero", d, 0);
        rd(5'h02, d); check("R2 misaligned read", d, 0);
        step(1, 5'h09, 32'h0, 0);                  check_all("R2 misaligned write");
        step(1, 5'h04, 32'hFFFF_FFFF, 0);          check_all("R8 pending write");
        step(1, 5'h18, 32'h0, 0);                  check_all("R8 vector write");

        // R7 enable set/clear
        step(1, 5'h10, 32'h0F0F_0000, 0);          check_all("R7 set");
        step(1, 5'h14, 32'h0000_00F0, 0);          check_all("R7 clear");
        step(1, 5'h08, 32'hFFFF_FFFF, 0);          check_all("R7 all");

        // R9 level follow, R6 ack on a held level
        step(0, 0, 0, 32'h0000_0008);              check_all("R9 level high");
        step(1, 5'h0C, 32'h8, 32'h0000_0008);      check_all("R6 level ack held");
        step(0, 0, 0, 0);                          check_all("R9 level low");

        // R10 edge capture and hold, R6 ack
        step(0, 0, 0, 32'h0010_0000);              check_all("R10 edge rise");
        step(0, 0, 0, 0);                          check_all("R10 edge held");
        step(1, 5'h0C, 32'h0010_0000, 0);          check_all("R6 edge ack");

        // R12 ack and rise together
        step(1, 5'h0C, 32'h0020_0000, 32'h0020_0000);
        check_all("R12 rise wins");
        rd(5'h00, d); check("R12 bit21", {31'd0, d[21]}, 32'd1);

        // R4 priority across edge sources
        step(0, 0, 0, 32'h4022_0000);              check_all("R4 priority");

        // R11 capture disabled
        step(1, 5'h1C, 32'h1, 0);                  check_all("R11 off");
        step(0, 0, 0, 32'h8001_00FF);              check_all("R11 ignore rise");
        step(0, 0, 0, 0);                          check_all("R11 ignore fall");
        step(1, 5'h00, 32'h0000_0003, 0);          check_all("R8 status write");
        step(1, 5'h1C, 32'h3, 0);                  check_all("R5 back on");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r = $urandom;
            logic [4:0]  a = {r[2:0], 2'b00};
            logic [31:0] wd = $urandom;
            if (r[7:4] == 0) a[1:0] = r[9:8];
            if (a[4:2] == 3'd7 && r[12:10] != 0) wd[1:0] = 2'b11;
            step(r[3], a, wd, $urandom & $urandom);
            check_all("RND R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule